// File: doc/BRIEF.md
# Masked Burst Address Counter

This block generates the address for one port of a synchronous dual-port memory. It keeps three registers: a running address counter, a mask that selects which counter bits may advance, and a mirror that remembers the last address loaded from outside. On every rising clock edge one command is carried out: clear the counter, write or restore the mask, load an external address, replay from the mirror, step the counter, or hold.

A step adds one only to the bits that the mask enables. Bits the mask disables keep their value. When every enabled bit is already 1, the step does not roll over to zero. It reloads the counter from the mirror and raises a one-cycle wrap flag, so a burst loops back to its own start address. A separate readback request returns either the counter or the mask on the address output for one cycle. The readback works alongside any command.

Top module: `burst_addr_ctr`

## Requirements
- R1: While rst_n is low and after it is released, the counter and mirror are 0, the mask is all ones, addr_oe is 0, wrap is 0 and addr_out is 0.
- R2: A load (addr_ld with no higher-priority command) copies addr_in into both the counter and the mirror on that edge.
- R3: A step (cnt_inc with no higher-priority command) adds one to the field formed by the counter bits whose mask bit is 1, with the lowest enabled bit as least significant. Counter bits whose mask bit is 0 do not change.
- R4: If all enabled bits are 1 when a step is taken (this includes an all-zero mask), the counter takes the mirror value and wrap is 1 for exactly the cycle after that edge. Otherwise wrap is 0.
- R5: cnt_rst sets the counter and the mirror to 0 on that edge with no lost cycle. A step on the next edge with the mask all ones then gives address 1.
- R6: retx reloads the counter from the mirror and does not raise wrap.
- R7: mask_ld writes addr_in into the mask, and mask_rst sets every mask bit to 1. During either mask command the counter is left unchanged.
- R8: When several commands are asserted on one edge, only the first in this order takes effect: cnt_rst, mask_rst, mask_ld, addr_ld, retx, cnt_inc.
- R9: rd_back samples the counter (rb_sel_cnt=1) or the mask (rb_sel_cnt=0) as they stood before the edge. In the following cycle only, addr_oe is 1 and addr_out carries that value. addr_out is 0 whenever addr_oe is 0.
- R10: With no command asserted, the counter, the mask and the mirror keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous master reset, active low |
| cnt_rst | input | 1 | Clear counter and mirror |
| mask_ld | input | 1 | Write addr_in into the mask |
| mask_rst | input | 1 | Set all mask bits to 1 |
| addr_ld | input | 1 | Load addr_in into counter and mirror |
| retx | input | 1 | Reload counter from mirror |
| cnt_inc | input | 1 | Step the enabled counter bits |
| rd_back | input | 1 | Request readback next cycle |
| rb_sel_cnt | input | 1 | Readback source: 1 counter, 0 mask |
| addr_in | input | AW | External address or mask value |
| addr_out | output | AW | Readback value, 0 when not driven |
| addr_oe | output | 1 | Readback valid strobe |
| wrap | output | 1 | Enabled field rolled over on the last edge |

## Verification
The step logic is swept over every mask and every start address at a 4-bit width, with three steps from each start. This covers contiguous low fields, scattered enabled bits, the all-ones mask that behaves as plain binary counting, and the all-zero mask that wraps on every step. Together these separate a correct masked carry from one that leaks into frozen bits, or that rolls to zero instead of to the mirror. Further directed sequences stack commands on one edge to check the priority order. They also confirm the clear-then-step result of 1, the replay without a wrap, and that the readback lasts exactly one cycle.

// File: rtl/bac_pkg.sv
package bac_pkg;

    typedef enum logic [2:0] {
        OP_HOLD = 3'd0,
        OP_CRST = 3'd1,
        OP_MRST = 3'd2,
        OP_MLD  = 3'd3,
        OP_ALD  = 3'd4,
        OP_RETX = 3'd5,
        OP_INC  = 3'd6
    } bac_op_e;

endpackage

// File: rtl/bac_op_sel.sv
module bac_op_sel
    import bac_pkg::*;
(
    input  logic    cnt_rst,
    input  logic    mask_rst,
    input  logic    mask_ld,
    input  logic    addr_ld,
    input  logic    retx,
    input  logic    cnt_inc,
    output bac_op_e op
);

    always_comb begin
        if (cnt_rst)       op = OP_CRST;
        else if (mask_rst) op = OP_MRST;
        else if (mask_ld)  op = OP_MLD;
        else if (addr_ld)  op = OP_ALD;
        else if (retx)     op = OP_RETX;
        else if (cnt_inc)  op = OP_INC;
        else               op = OP_HOLD;
    end

endmodule

// File: rtl/bac_mask_inc.sv
module bac_mask_inc #(
    parameter int AW = 18
) (
    input  logic [AW-1:0] cnt,
    input  logic [AW-1:0] mask,
    output logic [AW-1:0] stepped,
    output logic          carry_out
);

    logic [AW:0] carry;

    assign carry[0] = 1'b1;

    // Carry hops over disabled bits and ripples only through enabled ones.
    for (genvar i = 0; i < AW; i++) begin : g_bit
        assign stepped[i]  = mask[i] ? (cnt[i] ^ carry[i]) : cnt[i];
        assign carry[i+1]  = mask[i] ? (cnt[i] & carry[i]) : carry[i];
    end

    assign carry_out = carry[AW];

endmodule

// File: rtl/bac_rb_mux.sv
module bac_rb_mux #(
    parameter int AW = 18
) (
    input  logic          req,
    input  logic          sel_cnt,
    input  logic [AW-1:0] cnt,
    input  logic [AW-1:0] mask,
    output logic [AW-1:0] value
);

    always_comb begin
        if (!req)         value = '0;
        else if (sel_cnt) value = cnt;
        else              value = mask;
    end

endmodule

// File: rtl/burst_addr_ctr.sv
module burst_addr_ctr
    import bac_pkg::*;
#(
    parameter int AW = 18
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cnt_rst,
    input  logic          mask_ld,
    input  logic          mask_rst,
    input  logic          addr_ld,
    input  logic          retx,
    input  logic          cnt_inc,
    input  logic          rd_back,
    input  logic          rb_sel_cnt,
    input  logic [AW-1:0] addr_in,
    output logic [AW-1:0] addr_out,
    output logic          addr_oe,
    output logic          wrap
);

    typedef struct packed {
        logic [AW-1:0] cnt;
        logic [AW-1:0] mask;
        logic [AW-1:0] mir;
        logic [AW-1:0] rb;
        logic          oe;
        logic          wrap;
    } st_t;

    localparam logic [AW-1:0] ALL_ONES = {AW{1'b1}};

    st_t           st_d, st_q;
    bac_op_e       op;
    logic [AW-1:0] stepped;
    logic          carry_out;
    logic [AW-1:0] rb_value;

    bac_op_sel u_op_sel (
        .cnt_rst  (cnt_rst),
        .mask_rst (mask_rst),
        .mask_ld  (mask_ld),
        .addr_ld  (addr_ld),
        .retx     (retx),
        .cnt_inc  (cnt_inc),
        .op       (op)
    );

    bac_mask_inc #(.AW(AW)) u_inc (
        .cnt       (st_q.cnt),
        .mask      (st_q.mask),
        .stepped   (stepped),
        .carry_out (carry_out)
    );

    bac_rb_mux #(.AW(AW)) u_rb (
        .req     (rd_back),
        .sel_cnt (rb_sel_cnt),
        .cnt     (st_q.cnt),
        .mask    (st_q.mask),
        .value   (rb_value)
    );

    always_comb begin
        st_d      = st_q;
        st_d.wrap = 1'b0;
        st_d.oe   = rd_back;
        st_d.rb   = rb_value;
        unique case (op)
            OP_CRST: begin
                st_d.cnt = '0;
                st_d.mir = '0;
            end
            OP_MRST: st_d.mask = ALL_ONES;
            OP_MLD:  st_d.mask = addr_in;
            OP_ALD: begin
                st_d.cnt = addr_in;
                st_d.mir = addr_in;
            end
            OP_RETX: st_d.cnt = st_q.mir;
            OP_INC: begin
                if (carry_out) begin
                    st_d.cnt  = st_q.mir;
                    st_d.wrap = 1'b1;
                end else begin
                    st_d.cnt  = stepped;
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cnt  <= '0;
            st_q.mask <= ALL_ONES;
            st_q.mir  <= '0;
            st_q.rb   <= '0;
            st_q.oe   <= 1'b0;
            st_q.wrap <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign addr_out = st_q.rb;
    assign addr_oe  = st_q.oe;
    assign wrap     = st_q.wrap;

endmodule

// File: rtl/burst_addr_ctr_chk.sv
module burst_addr_ctr_chk #(
    parameter int AW = 18
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cnt_rst,
    input logic          mask_ld,
    input logic          mask_rst,
    input logic          addr_ld,
    input logic          retx,
    input logic          cnt_inc,
    input logic          rd_back,
    input logic [AW-1:0] addr_in,
    input logic [AW-1:0] cnt,
    input logic [AW-1:0] mask,
    input logic [AW-1:0] mir,
    input logic [AW-1:0] addr_out,
    input logic          addr_oe,
    input logic          wrap
);

    logic mask_op, ld_only, inc_only, idle;
    assign mask_op  = !cnt_rst && (mask_ld || mask_rst);
    assign ld_only  = addr_ld && !cnt_rst && !mask_ld && !mask_rst;
    assign inc_only = cnt_inc && !cnt_rst && !mask_ld && !mask_rst && !addr_ld && !retx;
    assign idle     = !cnt_rst && !mask_ld && !mask_rst && !addr_ld && !retx && !cnt_inc;

    p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ld_only |=> (cnt == $past(addr_in) && mir == $past(addr_in)));

    p_frozen_r3: assert property (@(posedge clk) disable iff (!rst_n)
        inc_only |=> (wrap || ((cnt ^ $past(cnt)) & ~$past(mask)) == '0));

    p_wrap_mirror_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |-> cnt == mir);

    p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_rst |=> (cnt == '0 && mir == '0));

    p_mask_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mask_op |=> $stable(cnt));

    p_mask_ones_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_rst && mask_rst) |=> &mask);

    p_rb_on_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_back |=> addr_oe);

    p_rb_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_back |=> !addr_oe);

    p_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !addr_oe |-> addr_out == '0);

    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        idle |=> ($stable(cnt) && $stable(mask) && $stable(mir)));

endmodule

bind burst_addr_ctr burst_addr_ctr_chk #(.AW(AW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cnt_rst  (cnt_rst),
    .mask_ld  (mask_ld),
    .mask_rst (mask_rst),
    .addr_ld  (addr_ld),
    .retx     (retx),
    .cnt_inc  (cnt_inc),
    .rd_back  (rd_back),
    .addr_in  (addr_in),
    .cnt      (st_q.cnt),
    .mask     (st_q.mask),
    .mir      (st_q.mir),
    .addr_out (addr_out),
    .addr_oe  (addr_oe),
    .wrap     (wrap)
);

// File: tb/burst_addr_ctr_tb.sv
module burst_addr_ctr_tb;

    localparam int W = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cnt_rst = 0, mask_ld = 0, mask_rst = 0, addr_ld = 0;
    logic         retx = 0, cnt_inc = 0, rd_back = 0, rb_sel_cnt = 0;
    logic [W-1:0] addr_in = '0;
    logic [W-1:0] addr_out;
    logic         addr_oe, wrap;

    int total = 0;
    int bad   = 0;

    always #5 clk = ~clk;

    burst_addr_ctr #(.AW(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .cnt_rst(cnt_rst), .mask_ld(mask_ld),
        .mask_rst(mask_rst), .addr_ld(addr_ld), .retx(retx), .cnt_inc(cnt_inc),
        .rd_back(rd_back), .rb_sel_cnt(rb_sel_cnt), .addr_in(addr_in),
        .addr_out(addr_out), .addr_oe(addr_oe), .wrap(wrap)
    );

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Drive one edge's commands, wait for the edge, sample 2 ns later.
    task automatic tick(input bit crst, input bit mrst, input bit mld, input bit ald,
                        input bit rtx, input bit inc, input bit rb, input bit sel,
                        input int din);
        cnt_rst = crst; mask_rst = mrst; mask_ld = mld; addr_ld = ald;
        retx = rtx; cnt_inc = inc; rd_back = rb; rb_sel_cnt = sel;
        addr_in = W'(din);
        @(posedge clk);
        #2;
        cnt_rst = 0; mask_rst = 0; mask_ld = 0; addr_ld = 0;
        retx = 0; cnt_inc = 0; rd_back = 0;
    endtask

    // Read the counter (sel=1) or mask (sel=0) through the readback path.
    task automatic peek(input bit sel, input string tag, input int exp);
        tick(0, 0, 0, 0, 0, 0, 1, sel, 0);
        chk({tag, " oe"}, int'(addr_oe), 1);
        chk(tag, int'(addr_out), exp);
    endtask

    function automatic int field_of(input int v, input int m);
        int f = 0; int k = 0;
        for (int i = 0; i < W; i++) if (m[i]) begin f |= v[i] << k; k++; end
        return f;
    endfunction

    function automatic int spread(input int f, input int m);
        int v = 0; int k = 0;
        for (int i = 0; i < W; i++) if (m[i]) begin v |= f[k] << i; k++; end
        return v;
    endfunction

    initial begin
        #2_000_000;
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int cur, mir, f, nbits, ew;
        #23;
        chk("R1 oe in reset", int'(addr_oe), 0);
        chk("R1 wrap in reset", int'(wrap), 0);
        chk("R1 out in reset", int'(addr_out), 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk); #2;
        chk("R1 oe after reset", int'(addr_oe), 0);
        peek(1, "R1 counter zero", 0);
        peek(0, "R1 mask ones", 15);

        // R3/R4 sweep: every mask and every start address, three steps each.
        for (int m = 0; m < 16; m++) begin
            tick(0, 0, 1, 0, 0, 0, 0, 0, m);
            peek(0, "R7 mask load", m);
            nbits = $countones(m[W-1:0]);
            for (int a = 0; a < 16; a++) begin
                tick(0, 0, 0, 1, 0, 0, 0, 0, a);
                cur = a; mir = a;
                for (int s = 0; s < 3; s++) begin
                    tick(0, 0, 0, 0, 0, 1, 1, 1, 0);
                    chk("R2/R3 value before step", int'(addr_out), cur);
                    f = field_of(cur, m);
                    if (f == (1 << nbits) - 1) begin
                        ew = 1; cur = mir;
                    end else begin
                        ew = 0; cur = (cur & ~m & 15) | spread(f + 1, m);
                    end
                    chk("R4 wrap flag", int'(wrap), ew);
                end
                peek(1, "R3/R4 value after steps", cur);
                chk("R4 wrap one cycle", int'(wrap), 0);
            end
        end

        // R7: mask reset, counter untouched.
        tick(0, 0, 0, 1, 0, 0, 0, 0, 6);
        tick(0, 1, 0, 0, 0, 1, 0, 0, 0);
        peek(0, "R7 mask reset ones", 15);
        peek(1, "R7 counter kept", 6);

        // R5: clear plus step on same edge, then step gives 1.
        tick(0, 0, 0, 1, 0, 0, 0, 0, 9);
        tick(1, 0, 0, 0, 0, 1, 1, 1, 0);
        chk("R5 read with clear sees old", int'(addr_out), 9);
        tick(0, 0, 0, 0, 0, 1, 0, 0, 0);
        peek(1, "R5 step after clear", 1);
        tick(0, 0, 0, 0, 0, 0, 0, 0, 0);
        tick(0, 0, 0, 0, 1, 0, 0, 0, 0);
        peek(1, "R5 mirror cleared", 0);

        // R6: replay from mirror, no wrap.
        tick(0, 0, 0, 1, 0, 0, 0, 0, 5);
        tick(0, 0, 0, 0, 0, 1, 0, 0, 0);
        tick(0, 0, 0, 0, 0, 1, 0, 0, 0);
        peek(1, "R6 stepped to 7", 7);
        tick(0, 0, 0, 0, 1, 0, 0, 0, 0);
        chk("R6 no wrap", int'(wrap), 0);
        peek(1, "R6 replay", 5);

        // R10: idle cycles keep everything.
        for (int i = 0; i < 4; i++) tick(0, 0, 0, 0, 0, 0, 0, 0, 12);
        peek(1, "R10 hold counter", 5);
        peek(0, "R10 hold mask", 15);

        // R8: priority stacks.
        tick(0, 0, 1, 1, 1, 1, 0, 0, 3);
        peek(0, "R8 mask load beats address load", 3);
        peek(1, "R8 counter kept under mask load", 5);
        tick(0, 1, 0, 0, 0, 0, 0, 0, 0);
        tick(0, 0, 0, 1, 1, 1, 0, 0, 10);
        peek(1, "R8 load beats replay and step", 10);
        tick(0, 0, 0, 0, 0, 1, 0, 0, 0);
        tick(0, 0, 0, 0, 1, 1, 0, 0, 0);
        peek(1, "R8 replay beats step", 10);
        tick(1, 1, 0, 1, 0, 0, 0, 0, 4);
        peek(1, "R8 clear beats all", 0);

        // R9: readback lasts exactly one cycle.
        tick(0, 0, 0, 0, 0, 0, 1, 0, 0);
        chk("R9 mask readback", int'(addr_out), 15);
        tick(0, 0, 0, 0, 0, 0, 0, 0, 0);
        chk("R9 oe drops", int'(addr_oe), 0);
        chk("R9 out zero", int'(addr_out), 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule